// File: doc/BRIEF.md
# Electrical Angle Phase Tracker

This block turns a free-running 32-bit encoder count into an electrical phase angle for one motor axis. Once per control cycle a start strobe launches one update. The block subtracts a stored offset from the encoder count to form a phase index. If that index has left the window of one electrical period, the block moves the offset by exactly one period in the right direction and forms the index again.

The wrapped index is then scaled into a full-scale 32-bit angle word. The scaling multiplies by a precomputed reciprocal of the period, so the block needs no divider. The angle word is meant to feed a sine/cosine generator further down the path.

The period, the reciprocal and the offset each have a synchronous load port. Software uses them to set the pole-pair geometry and the initial rotor alignment. The index and angle outputs are registered and are marked by a one-cycle valid pulse.

Top module: `phase_tracker`

## Requirements
- R1: While reset is held and on the first cycle after it, the offset reads 0, the index and angle outputs read 0 and valid is low. The period register resets to 1000 counts and the reciprocal register resets to 4294967.
- R2: For an update, the raw index is the encoder count minus the offset, taken modulo 2^32. If the raw index, read unsigned, is less than or equal to the period, the index output is that raw value and the offset is not changed. This includes an index exactly equal to the period.
- R3: If the raw index, read unsigned, is strictly greater than the period and its bit 31 is 0, the offset grows by one period. The index output is the encoder count minus the new offset.
- R4: If the raw index, read unsigned, is strictly greater than the period and its bit 31 is 1, the offset shrinks by one period. The index output is the encoder count minus the new offset.
- R5: An update moves the offset by at most one period, even when the encoder count has jumped several periods away. Later updates each move it one more period.
- R6: With the period at 0xFFFFFFFF, no raw index can exceed it, so the offset never changes on an update. The index output is then the plain difference between the count and the offset.
- R7: The angle output equals the low 32 bits of the product of the index output and the reciprocal value held at the update.
- R8: An update sampled on a clock edge sets the index and angle outputs and raises valid for exactly the following cycle. Without a start, valid is low, the index and angle outputs hold their values and the offset does not change.
- R9: An offset load replaces the stored offset at the next edge. When it coincides with a start, the loaded value wins for the stored offset, and that update's index is formed from the old offset.
- R10: A period load or a reciprocal load changes the value used by every update started after the edge that performs the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launches one update on this edge |
| enc_pos | input | 32 | Free-running encoder count |
| per_ld | input | 1 | Load strobe for the period register |
| per_in | input | 32 | New period in encoder counts |
| reci_ld | input | 1 | Load strobe for the reciprocal register |
| reci_in | input | 32 | New reciprocal, about 2^32 / period |
| ofs_ld | input | 1 | Load strobe for the offset register |
| ofs_in | input | 32 | New offset value |
| phase_idx | output | 32 | Wrapped phase index of the last update |
| phase_ang | output | 32 | Full-scale angle word of the last update |
| phase_vld | output | 1 | High for one cycle after each update |
| ofs_q | output | 32 | Current stored offset |

## Verification
The assertions check on every cycle the rules that can be seen one edge at a time. Valid follows start by one cycle. The offset stays put without a start or a load, and it moves by zero or one period per update. With an all-ones period it does not move at all. The reported index equals the sampled count minus the offset that results, and the angle equals the index times the reciprocal. The assertions cannot tell whether the direction of a move was the right one, whether the equal-to-period boundary stays unwrapped, or how a run of updates walks after a multi-period jump. The bench's vector table and its directed cases for loads, reset and the frozen period show those.

// File: rtl/phase_trk_pkg.sv
// Package: types shared by the phase tracker modules.
// Assumes: nothing; holds only the offset adjustment code.
package phase_trk_pkg;

    // Direction in which one update moves the stored offset.
    typedef enum logic [1:0] {
        ADJ_NONE = 2'd0,
        ADJ_FWD  = 2'd1,
        ADJ_BACK = 2'd2
    } adj_e;

endpackage

// File: rtl/phase_cfg_regs.sv
// Module: phase_cfg_regs
// Holds the period and reciprocal values. Each has its own load strobe
// and a reset default set by parameter.
// Assumes: loads are synchronous and take effect at the next edge.
module phase_cfg_regs #(
    parameter int unsigned       W        = 32,
    parameter logic [W-1:0]      PER_RST  = W'(1000),
    parameter logic [W-1:0]      RECI_RST = W'(4294967)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         per_ld,
    input  logic [W-1:0] per_in,
    input  logic         reci_ld,
    input  logic [W-1:0] reci_in,
    output logic [W-1:0] per_q,
    output logic [W-1:0] reci_q
);

    // Period register: reset default, else loaded on strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)       per_q <= PER_RST;
        else if (per_ld)  per_q <= per_in;
    end

    // Reciprocal register: reset default, else loaded on strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)       reci_q <= RECI_RST;
        else if (reci_ld) reci_q <= reci_in;
    end

endmodule

// File: rtl/phase_wrap_unit.sv
// Module: phase_wrap_unit
// Combinational. Forms the raw index, decides whether the offset has to
// move one period, and forms the wrapped index from the moved offset.
// Assumes: modular W-bit arithmetic. The comparison is strict, so an
// all-ones period never triggers a move.
module phase_wrap_unit
    import phase_trk_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] pos,
    input  logic [W-1:0] ofs,
    input  logic [W-1:0] per,
    output adj_e         adj,
    output logic [W-1:0] ofs_next,
    output logic [W-1:0] idx
);

    localparam int unsigned SIGN_BIT = W - 1;

    logic [W-1:0] raw;

    // Raw distance of the count from the current offset.
    always_comb raw = pos - ofs;

    // Pick the move direction from the strict test and the sign of raw.
    always_comb begin
        if (raw > per) adj = raw[SIGN_BIT] ? ADJ_BACK : ADJ_FWD;
        else           adj = ADJ_NONE;
    end

    // Moved offset, one period at most.
    always_comb begin
        unique case (adj)
            ADJ_FWD:  ofs_next = ofs + per;
            ADJ_BACK: ofs_next = ofs - per;
            default:  ofs_next = ofs;
        endcase
    end

    // Index measured from the moved offset.
    always_comb idx = pos - ofs_next;

endmodule

// File: rtl/phase_angle_scale.sv
// Module: phase_angle_scale
// Combinational. Scales the index to a full-scale angle by multiplying
// with the reciprocal and keeping the low W bits.
// Assumes: reci is about 2^W / period, so one period spans the full word.
module phase_angle_scale #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] idx,
    input  logic [W-1:0] reci,
    output logic [W-1:0] angle
);

    // Low half of the product; the wrap of the high half is intended.
    always_comb angle = idx * reci;

endmodule

// File: rtl/phase_tracker.sv
// Module: phase_tracker (top)
// Tracks the electrical phase of one axis from an encoder count. On start
// it moves the stored offset by at most one period and registers the
// wrapped index and the scaled angle, with a one-cycle valid pulse.
// Assumes: synchronous active-low reset. An offset load wins over an
// offset move in the same cycle.
module phase_tracker
    import phase_trk_pkg::*;
#(
    parameter int unsigned  W        = 32,
    parameter logic [W-1:0] PER_RST  = W'(1000),
    parameter logic [W-1:0] RECI_RST = W'(4294967)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] enc_pos,
    input  logic         per_ld,
    input  logic [W-1:0] per_in,
    input  logic         reci_ld,
    input  logic [W-1:0] reci_in,
    input  logic         ofs_ld,
    input  logic [W-1:0] ofs_in,
    output logic [W-1:0] phase_idx,
    output logic [W-1:0] phase_ang,
    output logic         phase_vld,
    output logic [W-1:0] ofs_q
);

    logic [W-1:0] per_q;
    logic [W-1:0] reci_q;
    adj_e         adj;
    logic [W-1:0] ofs_next;
    logic [W-1:0] idx_c;
    logic [W-1:0] ang_c;

    phase_cfg_regs #(.W(W), .PER_RST(PER_RST), .RECI_RST(RECI_RST)) cfg_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .per_ld  (per_ld),
        .per_in  (per_in),
        .reci_ld (reci_ld),
        .reci_in (reci_in),
        .per_q   (per_q),
        .reci_q  (reci_q)
    );

    phase_wrap_unit #(.W(W)) wrap_i (
        .pos      (enc_pos),
        .ofs      (ofs_q),
        .per      (per_q),
        .adj      (adj),
        .ofs_next (ofs_next),
        .idx      (idx_c)
    );

    phase_angle_scale #(.W(W)) scale_i (
        .idx   (idx_c),
        .reci  (reci_q),
        .angle (ang_c)
    );

    // Offset register: a load has priority, else it moves only on a wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)                           ofs_q <= '0;
        else if (ofs_ld)                      ofs_q <= ofs_in;
        else if (start && (adj != ADJ_NONE))  ofs_q <= ofs_next;
    end

    // Result registers: capture on start, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_idx <= '0;
            phase_ang <= '0;
        end else if (start) begin
            phase_idx <= idx_c;
            phase_ang <= ang_c;
        end
    end

    // Valid pulse: one cycle after each start.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_vld <= 1'b0;
        else        phase_vld <= start;
    end

endmodule

// File: rtl/phase_tracker_chk.sv
// Module: phase_tracker_chk
// Checker bound to phase_tracker. It watches the ports and the two
// configuration registers.
// Assumes: the same clock and synchronous active-low reset as the top.
module phase_tracker_chk #(
    parameter int unsigned W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic [W-1:0] enc_pos,
    input logic         ofs_ld,
    input logic [W-1:0] phase_idx,
    input logic [W-1:0] phase_ang,
    input logic         phase_vld,
    input logic [W-1:0] ofs_q,
    input logic [W-1:0] per_q,
    input logic [W-1:0] reci_q
);

    logic [W-1:0] reci_d;
    logic [W-1:0] ang_exp;
    logic [W-1:0] ofs_up;
    logic [W-1:0] ofs_dn;

    // Reciprocal as it stood at the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) reci_d <= '0;
        else        reci_d <= reci_q;
    end

    // Expected angle of the held index.
    always_comb ang_exp = phase_idx * reci_d;

    // Offsets one period away, for the step check.
    always_comb begin
        ofs_up = ofs_q + per_q;
        ofs_dn = ofs_q - per_q;
    end

    p_vld_follows_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> phase_vld);

    p_vld_low_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !phase_vld);

    p_ofs_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !ofs_ld) |=> $stable(ofs_q));

    p_ofs_one_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !ofs_ld) |=> (ofs_q == $past(ofs_q) || ofs_q == $past(ofs_up)
                                || ofs_q == $past(ofs_dn)));

    p_frozen_period_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !ofs_ld && (per_q == '1)) |=> $stable(ofs_q));

    p_idx_matches_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !ofs_ld) |=> (phase_idx == $past(enc_pos) - ofs_q));

    p_angle_scale_r7: assert property (@(posedge clk) disable iff (!rst_n)
        phase_vld |-> (phase_ang == ang_exp));

endmodule

bind phase_tracker phase_tracker_chk #(.W(W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .enc_pos   (enc_pos),
    .ofs_ld    (ofs_ld),
    .phase_idx (phase_idx),
    .phase_ang (phase_ang),
    .phase_vld (phase_vld),
    .ofs_q     (ofs_q),
    .per_q     (per_q),
    .reci_q    (reci_q)
);

// File: tb/phase_tracker_tb_top.sv
// Bench for phase_tracker. It walks a vector table with the default period
// and reciprocal, then runs directed cases for reset, loads and corners.
module phase_tracker_tb_top;

    localparam int unsigned W = 32;
    localparam logic [W-1:0] DEF_RECI = 32'd4294967;

    typedef struct packed {
        logic [W-1:0] pos;
        logic [W-1:0] idx;
        logic [W-1:0] ofs;
        logic [7:0]   req;
    } vec_t;

    // Period 1000, offset starting at 0; each row follows the row before.
    localparam vec_t VECS [9] = '{
        '{32'd500,        32'd500,        32'd0,    8'd2},  // R2 inside window
        '{32'd1000,       32'd1000,       32'd0,    8'd2},  // R2 equal: no wrap
        '{32'd1001,       32'd1,          32'd1000, 8'd3},  // R3 one past
        '{32'd2500,       32'd500,        32'd2000, 8'd3},  // R3 forward
        '{32'd1500,       32'd500,        32'd1000, 8'd4},  // R4 backward
        '{32'd10,         32'd10,         32'd0,    8'd4},  // R4 back to zero
        '{32'd5000,       32'd4000,       32'd1000, 8'd5},  // R5 single step
        '{32'd5000,       32'd3000,       32'd2000, 8'd5},  // R5 next step
        '{32'hFFFF_FFF0,  32'hFFFF_FC08,  32'd1000, 8'd5}   // R5 backward jump
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] enc_pos = '0;
    logic         per_ld = 1'b0;
    logic [W-1:0] per_in = '0;
    logic         reci_ld = 1'b0;
    logic [W-1:0] reci_in = '0;
    logic         ofs_ld = 1'b0;
    logic [W-1:0] ofs_in = '0;
    logic [W-1:0] phase_idx;
    logic [W-1:0] phase_ang;
    logic         phase_vld;
    logic [W-1:0] ofs_q;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    phase_tracker dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .enc_pos   (enc_pos),
        .per_ld    (per_ld),
        .per_in    (per_in),
        .reci_ld   (reci_ld),
        .reci_in   (reci_in),
        .ofs_ld    (ofs_ld),
        .ofs_in    (ofs_in),
        .phase_idx (phase_idx),
        .phase_ang (phase_ang),
        .phase_vld (phase_vld),
        .ofs_q     (ofs_q)
    );

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One update: drive at negedge, capture at posedge, leave at next negedge.
    task automatic run_update(input logic [W-1:0] pos);
        enc_pos = pos;
        start   = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start   = 1'b0;
    endtask

    task automatic load_ofs(input logic [W-1:0] v);
        ofs_in = v; ofs_ld = 1'b1;
        @(posedge clk); @(negedge clk);
        ofs_ld = 1'b0;
    endtask

    task automatic load_per(input logic [W-1:0] v);
        per_in = v; per_ld = 1'b1;
        @(posedge clk); @(negedge clk);
        per_ld = 1'b0;
    endtask

    task automatic load_reci(input logic [W-1:0] v);
        reci_in = v; reci_ld = 1'b1;
        @(posedge clk); @(negedge clk);
        reci_ld = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: values while reset is held.
        check("R1 vld in reset", {31'd0, phase_vld}, 32'd0);
        check("R1 ofs in reset", ofs_q, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idx", phase_idx, 32'd0);
        check("R1 ang", phase_ang, 32'd0);
        check("R1 vld", {31'd0, phase_vld}, 32'd0);
        check("R1 ofs", ofs_q, 32'd0);
        // R1: default period 1000 shows as no wrap at 1000, wrap at 1001.
        run_update(32'd1000);
        check("R1 default period", ofs_q, 32'd0);
        check("R1 default reci", phase_ang, 32'(32'd1000 * DEF_RECI));
        run_update(32'd0);

        // Vector table with the default settings.
        for (int i = 0; i < 9; i++) begin
            run_update(VECS[i].pos);
            check($sformatf("R%0d idx row %0d", VECS[i].req, i), phase_idx, VECS[i].idx);
            check($sformatf("R%0d ofs row %0d", VECS[i].req, i), ofs_q, VECS[i].ofs);
            check($sformatf("R7 ang row %0d", i), phase_ang, 32'(VECS[i].idx * DEF_RECI));
            check($sformatf("R8 vld row %0d", i), {31'd0, phase_vld}, 32'd1);
        end

        // R8: valid drops, outputs and offset hold without start.
        enc_pos = 32'd123456;
        @(negedge clk);
        check("R8 vld low", {31'd0, phase_vld}, 32'd0);
        check("R8 idx hold", phase_idx, 32'hFFFF_FC08);
        check("R8 ofs hold", ofs_q, 32'd1000);

        // R9: offset load, then an update measured from it.
        load_ofs(32'h100);
        check("R9 ofs loaded", ofs_q, 32'h100);
        run_update(32'h150);
        check("R9 idx from loaded ofs", phase_idx, 32'h50);

        // R9: load together with start; loaded value wins, idx from old ofs.
        enc_pos = 32'h180; start = 1'b1; ofs_in = 32'h40; ofs_ld = 1'b1;
        @(posedge clk); @(negedge clk);
        start = 1'b0; ofs_ld = 1'b0;
        check("R9 ofs wins", ofs_q, 32'h40);
        check("R9 idx old ofs", phase_idx, 32'h80);

        // R10: period load 200 changes the wrap point.
        load_ofs(32'd0);
        load_per(32'd200);
        run_update(32'd201);
        check("R10 new period ofs", ofs_q, 32'd200);
        check("R10 new period idx", phase_idx, 32'd1);

        // R10: reciprocal load.
        load_reci(32'h0001_0000);
        run_update(32'd250);
        check("R10 new reci ang", phase_ang, 32'd50 << 16);

        // R6: an all-ones period freezes the offset.
        load_per(32'hFFFF_FFFF);
        run_update(32'h8000_0000);
        check("R6 ofs frozen", ofs_q, 32'd200);
        check("R6 idx plain", phase_idx, 32'h7FFF_FF38);
        run_update(32'd5);
        check("R6 ofs frozen neg", ofs_q, 32'd200);
        check("R6 idx plain neg", phase_idx, 32'hFFFF_FF3D);

        // R1: reset again restores the defaults.
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        run_update(32'd1001);
        check("R1 period after reset", ofs_q, 32'd1000);
        check("R1 reci after reset", phase_ang, DEF_RECI);

        finish_run();
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

endmodule